// File: doc/BRIEF.md
# Glitchless two-input clock switch

This block picks one of two free-running, unrelated clocks and drives it onto a single output clock. The choice comes from a select input that may change at any time with respect to either clock. When the select changes, the output never shows a shortened high or low phase. The clock that was feeding the output is shut off low on one of its own falling edges. The output then rests low. The newly chosen clock is switched in on one of its own falling edges, so the first new high phase is always a whole one.

Each input has its own gate. The gate is driven by an enable synchronizer that is clocked on the falling edge of that input. Each enable may only rise while the other path's enable chain is empty, so the two gates are never open together. If the clock being left has stopped, its enable cannot clear by itself. In that case the incoming path counts its own falling edges while it waits. After a set limit it forces the stale enable off, so a switch away from a dead clock still completes. A switch onto a dead clock leaves the output low until that clock starts running.

The select must be held for at least 250 periods of the slower input between changes. The two inputs may differ in frequency by up to the configured ratio, which is ten by default. Reset clears both gates, and the select is expected to rest low (input 0) when nothing drives it.

Top module: `gcs_clk_switch`

## Requirements
- R1: While `rst_n` is low, `clk_out` is held low. After reset is released with `sel` low, `clk_out` follows `clk_in0`.
- R2: After `sel` changes, `clk_out` passes two to three more falling edges of the clock being left, counting from the change, and is then held low.
- R3: After the old clock is shut off, `clk_out` stays low for at most three falling edges of the new clock. It then starts on a rising edge of the new clock with a full-width high phase.
- R4: The two input gates are never open at the same time. Every high or low phase on `clk_out` lasts at least half a period of the faster input, including across switches between inputs whose frequencies differ by a factor of ten.
- R5: Selecting a stopped clock leaves `clk_out` low, with no edges. Once that clock runs again, `clk_out` follows it.
- R6: Selecting a running clock while the old clock has stopped (with its enable still set) forces the old enable off after `TMO_CYCLES` falling edges of the new clock. `clk_out` does not start earlier than that, and afterwards it follows the new clock.
- R7: The select encoding is fixed: `sel` = 0 routes `clk_in0` and `sel` = 1 routes `clk_in1`. The chosen clock appears with its own period and high time.
- R8: Activity on the clock that is not selected, including one that restarts after a stop, has no effect on `clk_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in0 | input | 1 | Input clock routed when `sel` is 0 |
| clk_in1 | input | 1 | Input clock routed when `sel` is 1 |
| sel | input | 1 | Asynchronous source select, 0 picks `clk_in0` |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_out | output | 1 | Switched output clock |

## Verification
Consider a wrong internal state, such as an enable left set or a synchronizer stage skipped. It shows at the output within a few cycles of the slower clock. It appears as a high phase that is short or stretched, or as extra pulses of the old clock after a change, or as a low gap longer than three new-clock edges. A force path that fires too early or never fires shows up on the first switch away from a stopped clock. The output either starts before the timeout window has run out, or never starts at all. For that reason the bench measures every phase width on `clk_out`, counts old-clock pulses after each select change, and times the restart after a stopped source.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
package gcs_pkg;
   // number of selectable input clocks
   localparam int unsigned SRC_COUNT = 2;

   // width of a counter that must reach the value limit
   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/gcs_bit_sync.sv
`timescale 1ns/1ps
// Falling-edge multi-stage synchronizer for a single bit.
module gcs_bit_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gcs_bit_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(negedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gcs_path.sv
`timescale 1ns/1ps
// One input path: enable synchronizer, gate, and stale-peer timeout.
module gcs_path #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TMO_CYCLES  = 64
) (
   input  logic clk,          // this path's input clock
   input  logic arst_n,       // block reset
   input  logic req,          // select asks for this path
   input  logic other_claim,  // peer chain holds any set stage
   input  logic other_en,     // peer gate enable
   input  logic force_off,    // peer demands this path be cleared
   output logic en,           // gate enable of this path
   output logic claim,        // any stage of this chain set
   output logic gclk,         // gated clock
   output logic force_other   // demand that the peer be cleared
);
   localparam int unsigned CW = gcs_pkg::cnt_bits(TMO_CYCLES);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gcs_path: SYNC_STAGES must be at least 2");
   end
   if (TMO_CYCLES < 4) begin : g_bad_tmo
      $error("gcs_path: TMO_CYCLES must be at least 4");
   end

   // domain-local reset: asserted async, released on this clock
   logic dom_rst_n;
   gcs_bit_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
      .clk   (clk),
      .arst_n(arst_n),
      .d     (1'b1),
      .q     (dom_rst_n)
   );

   // the enable chain may also be cleared by the peer's timeout
   logic prst_n;
   assign prst_n = dom_rst_n & ~force_off;

   logic [SYNC_STAGES-1:0] en_chain;
   logic                   chain_in;
   assign chain_in = req & ~other_claim;

   always_ff @(negedge clk or negedge prst_n) begin
      if (!prst_n) en_chain <= '0;
      else         en_chain <= {en_chain[SYNC_STAGES-2:0], chain_in};
   end

   assign en    = en_chain[SYNC_STAGES-1];
   assign claim = |en_chain;
   // en only moves while clk is low, so the AND never truncates a phase
   assign gclk  = clk & en;

   // peer enable seen in this domain
   logic other_en_s;
   gcs_bit_sync #(.STAGES(2), .RST_VAL(1'b0)) u_peer_sync (
      .clk   (clk),
      .arst_n(dom_rst_n),
      .d     (other_en),
      .q     (other_en_s)
   );

   // count own falling edges while waiting on a peer that does not let go
   logic [CW-1:0] wait_cnt;
   logic          force_q;
   logic          waiting;
   assign waiting = req & other_en_s;

   always_ff @(negedge clk or negedge dom_rst_n) begin
      if (!dom_rst_n) begin
         wait_cnt <= '0;
         force_q  <= 1'b0;
      end else if (!waiting) begin
         wait_cnt <= '0;
         force_q  <= 1'b0;
      end else if (wait_cnt == CW'(TMO_CYCLES)) begin
         force_q  <= 1'b1;
      end else begin
         wait_cnt <= wait_cnt + CW'(1);
      end
   end

   assign force_other = force_q;

   // R4: a gate opens only while the peer chain is empty
   p_open_excl_r4: assert property (@(negedge clk) disable iff (!prst_n)
      $rose(en) |-> !other_claim)
      else $error("p_open_excl_r4");

   // R6: a forcing demand is withdrawn once this path is no longer wanted
   p_force_drop_r6: assert property (@(negedge clk) disable iff (!dom_rst_n)
      (force_other && !req) |=> !force_other)
      else $error("p_force_drop_r6");

   if (SYNC_STAGES == 2) begin : g_two_stage_checks
      // R2: two falling edges without the request close the gate
      p_release_r2: assert property (@(negedge clk) disable iff (!prst_n)
         (!req && $past(!req)) |=> !en)
         else $error("p_release_r2");

      // R3: a gate opens two falling edges after a request was sampled
      p_open_req_r3: assert property (@(negedge clk) disable iff (!prst_n)
         $rose(en) |-> $past(req, 2))
         else $error("p_open_req_r3");
   end
endmodule

// File: rtl/gcs_clk_switch.sv
`timescale 1ns/1ps
// Glitchless switch between two unrelated clocks.
module gcs_clk_switch #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MAX_RATIO   = 10,
   parameter int unsigned TMO_CYCLES  = 64
) (
   input  logic clk_in0,
   input  logic clk_in1,
   input  logic sel,
   input  logic rst_n,
   output logic clk_out
);
   localparam int unsigned NS = gcs_pkg::SRC_COUNT;
   // a live but slow old clock needs up to three of its periods to let go
   localparam int unsigned MIN_TMO = 3 * MAX_RATIO + SYNC_STAGES;

   if (MAX_RATIO < 1) begin : g_bad_ratio
      $error("gcs_clk_switch: MAX_RATIO must be at least 1");
   end
   if (TMO_CYCLES <= MIN_TMO) begin : g_bad_tmo
      $error("gcs_clk_switch: TMO_CYCLES too small for MAX_RATIO");
   end

   logic [NS-1:0] clk_v, req_v, en_v, claim_v, gclk_v, force_v;

   assign clk_v = {clk_in1, clk_in0};
   assign req_v = {sel, ~sel};

   for (genvar i = 0; i < NS; i++) begin : g_path
      localparam int unsigned PEER = NS - 1 - i;
      gcs_path #(
         .SYNC_STAGES(SYNC_STAGES),
         .TMO_CYCLES (TMO_CYCLES)
      ) u_path (
         .clk        (clk_v[i]),
         .arst_n     (rst_n),
         .req        (req_v[i]),
         .other_claim(claim_v[PEER]),
         .other_en   (en_v[PEER]),
         .force_off  (force_v[PEER]),
         .en         (en_v[i]),
         .claim      (claim_v[i]),
         .gclk       (gclk_v[i]),
         .force_other(force_v[i])
      );
   end

   assign clk_out = |gclk_v;

   // R4: never two open gates
   always_comb begin
      if (rst_n) begin
         p_one_gate_r4: assert ($countones(en_v) <= 1)
            else $error("p_one_gate_r4");
      end
   end
endmodule

// File: tb/gcs_clk_switch_test.sv
`timescale 1ns/1ps
module gcs_clk_switch_test;
   localparam real T0  = 4.0;   // 250 MHz
   localparam real T1  = 40.0;  // ten times slower
   localparam int  TMO = 64;

   logic clk_in0 = 1'b0;
   logic clk_in1 = 1'b0;
   logic run0 = 1'b1;
   logic run1 = 1'b1;
   logic sel = 1'b0;
   logic rst_n = 1'b0;
   logic clk_out;

   always begin #(T0/2); clk_in0 = run0 ? ~clk_in0 : 1'b0; end
   always begin #(T1/2); clk_in1 = run1 ? ~clk_in1 : 1'b0; end

   gcs_clk_switch #(.SYNC_STAGES(2), .MAX_RATIO(10), .TMO_CYCLES(TMO)) uut (
      .clk_in0(clk_in0),
      .clk_in1(clk_in1),
      .sel    (sel),
      .rst_n  (rst_n),
      .clk_out(clk_out)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   function automatic bit near(real a, real b);
      return ((a - b) < 0.01) && ((b - a) < 0.01);
   endfunction

   task automatic check(bit ok, string rq, string what, real act, real exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0.3f expected=%0.3f", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // ---------------- edge tracker: phase widths and handover counts
   real last_rise = -1.0, last_fall = -1.0;
   real mark_t = 1.0e9, old_w = 0.0, new_w = 0.0;
   real first_new = -1.0, last_old_fall = -1.0, runt_w = 0.0;
   int  cnt_old = 0, rise_cnt = 0, runts = 0;

   always @(posedge clk_out) begin
      if (last_fall >= 0.0 && ($realtime - last_fall) < (T0/2 - 0.01)) begin
         runts++;
         runt_w = $realtime - last_fall;
      end
      last_rise = $realtime;
      rise_cnt++;
   end

   always @(negedge clk_out) begin : b_fall
      real w;
      w = $realtime - last_rise;
      last_fall = $realtime;
      if (!(near(w, T0/2) || near(w, T1/2))) begin
         runts++;
         runt_w = w;
      end
      if ($realtime > mark_t && first_new < 0.0) begin
         if (near(w, old_w)) begin
            cnt_old++;
            last_old_fall = $realtime;
         end else if (near(w, new_w)) begin
            first_new = last_rise;
         end
      end
   end

   // ---------------- scoreboard
   typedef struct {
      int    src;
      int    pulses;
      string rq;
   } item_t;

   item_t sb_q[$];
   bit    sb_busy = 1'b0;

   task automatic push_expect(int src, int pulses, string rq);
      item_t it;
      it.src = src;
      it.pulses = pulses;
      it.rq = rq;
      sb_busy = 1'b1;
      sb_q.push_back(it);
      wait (!sb_busy);
   endtask

   initial begin : b_monitor
      forever begin : b_item
         item_t it;
         real r0, r1, hw, per, exp_hw, bad_v;
         bit bad;
         wait (sb_q.size() > 0);
         it = sb_q.pop_front();
         exp_hw = (it.src == 0) ? T0/2 : T1/2;
         bad = 1'b0;
         bad_v = exp_hw;
         @(posedge clk_out);
         r0 = $realtime;
         for (int k = 0; k < it.pulses; k++) begin
            @(negedge clk_out);
            hw = $realtime - r0;
            @(posedge clk_out);
            r1 = $realtime;
            per = r1 - r0;
            r0 = r1;
            if (!near(hw, exp_hw) || !near(per, 2.0*exp_hw)) begin
               bad = 1'b1;
               bad_v = hw;
            end
         end
         check(!bad, it.rq, $sformatf("output follows clk_in%0d (high time)", it.src),
               bad_v, exp_hw);
         sb_busy = 1'b0;
      end
   end

   // ---------------- select change with handover measurement (R2, R3)
   task automatic handover(int to);
      real gap, tnew;
      tnew  = (to == 0) ? T0 : T1;
      old_w = (to == 0) ? T1/2 : T0/2;
      new_w = (to == 0) ? T0/2 : T1/2;
      cnt_old = 0;
      first_new = -1.0;
      last_old_fall = -1.0;
      if (to == 1) begin @(posedge clk_in0); #0.5; end
      else         begin @(posedge clk_in1); #1.0; end
      mark_t = $realtime;
      sel = (to == 1);
      #(6*T1);
      check(cnt_old >= 2 && cnt_old <= 3, "R2", "old-clock falling edges after select change",
            cnt_old, 2);
      gap = first_new - last_old_fall;
      check(first_new > 0.0 && gap > 0.0 && gap < 3.5*tnew, "R3",
            "low gap before new clock starts", gap, 3.0*tnew);
      mark_t = 1.0e9;
   endtask

   // ---------------- stimulus
   initial begin : b_main
      int  r;
      real t, dt;
      // R1: output low throughout reset, sampled in clk_in0 high phase
      for (int k = 0; k < 3; k++) begin
         @(posedge clk_in0); #1.0;
         check(clk_out == 1'b0, "R1", "clk_out during reset", clk_out, 0);
         #(3*T0);
      end
      rst_n = 1'b1;
      #(10*T0);
      push_expect(0, 10, "R1");                 // follows in0 after reset

      handover(1);                              // 250 MHz -> 25 MHz
      push_expect(1, 6, "R7");                  // sel=1 picks clk_in1
      handover(0);                              // 25 MHz -> 250 MHz
      push_expect(0, 10, "R7");                 // sel=0 picks clk_in0

      // R5: switch onto a stopped clock
      run1 = 1'b0;
      #(2*T1);
      @(posedge clk_in0); #0.5;
      sel = 1'b1;
      #(4*T0);
      r = rise_cnt;
      #(400.0);
      check(rise_cnt == r, "R5", "edges while target clock stopped", rise_cnt - r, 0);
      check(clk_out == 1'b0, "R5", "output level while target stopped", clk_out, 0);
      run1 = 1'b1;
      #(6*T1);
      push_expect(1, 6, "R5");                  // resumes on revived clock

      // R6: switch away from a stopped clock
      run1 = 1'b0;
      #(T1);
      t = $realtime;
      r = rise_cnt;
      sel = 1'b0;
      wait (rise_cnt > r);
      dt = $realtime - t;
      check(dt >= TMO*T0, "R6", "restart delay lower bound", dt, TMO*T0);
      check(dt <= (TMO+12)*T0, "R6", "restart delay upper bound", dt, (TMO+12)*T0);
      push_expect(0, 10, "R6");

      // R8: deselected clock restarts, output unaffected
      run1 = 1'b1;
      #(3*T1);
      push_expect(0, 20, "R8");

      // R4: no runt phase anywhere in the run
      check(runts == 0, "R4", "runt phases on clk_out", runt_w, 0);

      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin : b_watchdog
      #(100000.0);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule